// File: doc/BRIEF.md
# Accelerator Launch and Completion Register Slave

This block is the software-facing register window of a hardware accelerator. A bus master sees a set of 64-bit words, one per 8-byte-aligned byte address. It loads the accelerator's arguments into some of these words, then launches the core by writing a command word. The block turns that write into a single-cycle start pulse and raises a busy flag until the core signals completion.

On completion the block captures the core's 192-bit result and raises a done flag. It also raises a sticky interrupt status bit, which the master clears by writing a one. The interrupt line is that status gated by a software enable. Argument and result values wider than a bus word occupy consecutive words, with the lowest bits at the lowest address. Bits of a word that carry no field read back as zero and ignore writes.

Top module: `acc_csr_slave`

## Requirements
- R1: After reset, busy, done, interrupt status, interrupt enable, the captured result and every argument are zero, start_o is low and irq_o is low.
- R2: The arguments are read/write at these byte addresses: a 32-bit value at 0x38 (bits 31:0), a 192-bit value at 0x40/0x48/0x50 (bits 63:0 at 0x40), a 64-bit value at 0x58 and an 8-bit value at 0x60 (bits 7:0). A write changes only the bytes whose byteenable bit is set. Bits above a field's width ignore writes and read as zero. The stored values drive arg_a_o, arg_b_o, arg_c_o and arg_d_o.
- R3: A write to 0x08 with byteenable bit 0 set and writedata bit 0 equal to 1, made while busy is 0, produces start_o high for exactly the one cycle after the write cycle and sets busy in that same cycle. Any other write to 0x08 starts nothing. 0x08 reads as zero.
- R4: A start write made while busy is 1 is ignored: start_o stays low and busy stays set.
- R5: Busy reads at 0x00 bit 0 and on busy_o. It stays set until a cycle in which core_done_i is high, and it is clear in the cycle after that one.
- R6: core_done_i while busy is a completion. A completion latches ret_data_i into the result words 0x20/0x28/0x30 (bits 63:0 at 0x20) and sets the done flag at 0x18 bit 1. An accepted start clears done. core_done_i while not busy is ignored.
- R7: A completion sets the interrupt status at 0x18 bit 0. Writing 0x18 with byteenable bit 0 set and writedata bit 0 equal to 1 clears it. Done is not writable. If a completion and a clear fall in the same cycle, the status stays set.
- R8: The interrupt enable is read/write at 0x10 bit 0. irq_o is high exactly when both the interrupt status and the enable are 1.
- R9: Read data appears on readdata_o in the cycle after read_i and holds until the next read. Unmapped, misaligned (address bits 2:0 nonzero) and write-only addresses read zero. Writes to those addresses, and writes to read-only words, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| address_i | input | 8 | Byte address |
| write_i | input | 1 | Write strobe |
| writedata_i | input | 64 | Write data |
| byteenable_i | input | 8 | Per-byte write enables |
| read_i | input | 1 | Read strobe |
| readdata_o | output | 64 | Read data, one cycle after read_i |
| start_o | output | 1 | Start pulse to the core |
| busy_o | output | 1 | Core is running |
| core_done_i | input | 1 | Completion pulse from the core |
| ret_data_i | input | 192 | Result from the core |
| arg_a_o | output | 32 | 32-bit argument |
| arg_b_o | output | 192 | 192-bit argument |
| arg_c_o | output | 64 | 64-bit argument |
| arg_d_o | output | 8 | 8-bit argument |
| irq_o | output | 1 | Interrupt line |

## Verification
Read data is due one cycle after read_i. A scoreboard queue takes the expected word when the read is driven, and the monitor pops it at the falling edge after the edge that sampled the read. start_o and busy_o are due in the cycle after the start write: the bench checks them at the next falling edge, and checks the next cycle again to confirm the pulse has ended. Completion effects (busy clear, irq_o, status and result words) are due in the cycle after core_done_i, and irq_o after an enable write or clear is due one cycle after that write. Both are sampled at the first falling edge after the causing edge.

// File: rtl/acc_csr_pkg.sv
`timescale 1ns/1ps
package acc_csr_pkg;
  localparam int DATA_W  = 64;
  localparam int ADDR_W  = 8;
  localparam int RET_W   = 192;
  localparam int ARG_A_W = 32;
  localparam int ARG_B_W = 192;
  localparam int ARG_C_W = 64;
  localparam int ARG_D_W = 8;

  // word indices whose position is fixed by the control protocol
  localparam int IDX_BUSY  = 0;
  localparam int IDX_START = 1;
  localparam int IDX_IE    = 2;
  localparam int IDX_STS   = 3;
  localparam int IDX_RET   = 4;

  function automatic int words_for(input int w, input int dw);
    return (w + dw - 1) / dw;
  endfunction
endpackage

// File: rtl/csr_arg_field.sv
`timescale 1ns/1ps
module csr_arg_field #(
  parameter int W    = 32,
  parameter int BASE = 7,
  parameter int DW   = 64,
  parameter int IW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] wmask_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  val_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int NW = (W + DW - 1) / DW;

  function automatic logic [DW-1:0] low_ones(input int n);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < n);
    return m;
  endfunction

  logic [NW*DW-1:0] flat;

  for (genvar k = 0; k < NW; k++) begin : g_word
    localparam int VB = ((W - k*DW) >= DW) ? DW : (W - k*DW);
    localparam logic [DW-1:0] KEEP = low_ones(VB);
    logic [DW-1:0] q;
    logic [DW-1:0] m;
    assign m = wmask_i & KEEP;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && wr_idx_i == IW'(BASE + k)) q <= (q & ~m) | (wdata_i & m);
    end
    assign flat[k*DW +: DW] = q;
  end

  assign val_o = flat[W-1:0];

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NW; k++)
      if (rd_idx_i == IW'(BASE + k)) rd_data_o = flat[k*DW +: DW];
  end
endmodule

// File: rtl/csr_ctrl.sv
`timescale 1ns/1ps
module csr_ctrl #(
  parameter int RW = 192
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_req_i,
  input  logic          ie_wr_i,
  input  logic          ie_val_i,
  input  logic          sts_clr_i,
  input  logic          core_done_i,
  input  logic [RW-1:0] ret_data_i,
  output logic          start_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          sts_o,
  output logic          ie_o,
  output logic          irq_o,
  output logic [RW-1:0] ret_o
);
  logic busy_q, done_q, sts_q, ie_q, start_q;
  logic [RW-1:0] ret_q;
  logic accept, complete;

  assign accept   = start_req_i && !busy_q;
  assign complete = core_done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sts_q   <= 1'b0;
      ie_q    <= 1'b0;
      start_q <= 1'b0;
      ret_q   <= '0;
    end else begin
      start_q <= accept;
      if (accept)        busy_q <= 1'b1;
      else if (complete) busy_q <= 1'b0;
      if (accept)        done_q <= 1'b0;
      else if (complete) done_q <= 1'b1;
      // completion wins over a same-cycle clear
      if (complete)       sts_q <= 1'b1;
      else if (sts_clr_i) sts_q <= 1'b0;
      if (ie_wr_i) ie_q <= ie_val_i;
      if (complete) ret_q <= ret_data_i;
    end
  end

  assign start_o = start_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign sts_o   = sts_q;
  assign ie_o    = ie_q;
  assign irq_o   = sts_q & ie_q;
  assign ret_o   = ret_q;

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R4
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_req_i) |=> !start_o);
  // R5
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !core_done_i) |=> busy_q);
  // R6 R7
  complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_done_i && busy_q) |=> (done_q && sts_q && !busy_q));
endmodule

// File: rtl/acc_csr_slave.sv
`timescale 1ns/1ps
module acc_csr_slave
  import acc_csr_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int RW  = RET_W,
  parameter int AAW = ARG_A_W,
  parameter int ABW = ARG_B_W,
  parameter int ACW = ARG_C_W,
  parameter int ADW = ARG_D_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     address_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] writedata_i,
  input  logic [DATA_W/8-1:0] byteenable_i,
  input  logic              read_i,
  output logic [DATA_W-1:0] readdata_o,
  output logic              start_o,
  output logic              busy_o,
  input  logic              core_done_i,
  input  logic [RW-1:0]     ret_data_i,
  output logic [AAW-1:0]    arg_a_o,
  output logic [ABW-1:0]    arg_b_o,
  output logic [ACW-1:0]    arg_c_o,
  output logic [ADW-1:0]    arg_d_o,
  output logic              irq_o
);
  localparam int DW    = DATA_W;
  localparam int BW    = DW / 8;
  localparam int OFS   = $clog2(BW);
  localparam int IW    = AW - OFS;
  localparam int RET_N = words_for(RW, DW);
  localparam int IDX_A = IDX_RET + RET_N;
  localparam int IDX_B = IDX_A + words_for(AAW, DW);
  localparam int IDX_C = IDX_B + words_for(ABW, DW);
  localparam int IDX_D = IDX_C + words_for(ACW, DW);
  localparam int IDX_LAST = IDX_D + words_for(ADW, DW) - 1;

  logic [IW-1:0] idx;
  logic          aligned, wr, rd;
  logic [DW-1:0] wmask;

  assign idx     = address_i[AW-1:OFS];
  assign aligned = (address_i[OFS-1:0] == '0);
  assign wr      = write_i && aligned;
  assign rd      = read_i && aligned;

  for (genvar b = 0; b < BW; b++) begin : g_be
    assign wmask[b*8 +: 8] = {8{byteenable_i[b]}};
  end

  logic start_req, ie_wr, sts_clr;
  assign start_req = wr && idx == IW'(IDX_START) && wmask[0] && writedata_i[0];
  assign ie_wr     = wr && idx == IW'(IDX_IE) && wmask[0];
  assign sts_clr   = wr && idx == IW'(IDX_STS) && wmask[0] && writedata_i[0];

  logic done, sts, ie;
  logic [RW-1:0] ret;

  csr_ctrl #(.RW(RW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_req_i (start_req),
    .ie_wr_i     (ie_wr),
    .ie_val_i    (writedata_i[0]),
    .sts_clr_i   (sts_clr),
    .core_done_i (core_done_i),
    .ret_data_i  (ret_data_i),
    .start_o     (start_o),
    .busy_o      (busy_o),
    .done_o      (done),
    .sts_o       (sts),
    .ie_o        (ie),
    .irq_o       (irq_o),
    .ret_o       (ret)
  );

  logic [DW-1:0] rd_a, rd_b, rd_c, rd_d;

  csr_arg_field #(.W(AAW), .BASE(IDX_A), .DW(DW), .IW(IW)) u_arg_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wr_idx_i(idx), .wdata_i(writedata_i),
    .wmask_i(wmask), .rd_idx_i(idx), .val_o(arg_a_o), .rd_data_o(rd_a));
  csr_arg_field #(.W(ABW), .BASE(IDX_B), .DW(DW), .IW(IW)) u_arg_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wr_idx_i(idx), .wdata_i(writedata_i),
    .wmask_i(wmask), .rd_idx_i(idx), .val_o(arg_b_o), .rd_data_o(rd_b));
  csr_arg_field #(.W(ACW), .BASE(IDX_C), .DW(DW), .IW(IW)) u_arg_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wr_idx_i(idx), .wdata_i(writedata_i),
    .wmask_i(wmask), .rd_idx_i(idx), .val_o(arg_c_o), .rd_data_o(rd_c));
  csr_arg_field #(.W(ADW), .BASE(IDX_D), .DW(DW), .IW(IW)) u_arg_d (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wr_idx_i(idx), .wdata_i(writedata_i),
    .wmask_i(wmask), .rd_idx_i(idx), .val_o(arg_d_o), .rd_data_o(rd_d));

  logic [RET_N*DW-1:0] ret_flat;
  logic [DW-1:0]       rd_mux, rdata_q;
  assign ret_flat = (RET_N*DW)'(ret);

  always_comb begin
    rd_mux = rd_a | rd_b | rd_c | rd_d;
    if (idx == IW'(IDX_BUSY)) rd_mux = DW'(busy_o);
    if (idx == IW'(IDX_IE))   rd_mux = DW'(ie);
    if (idx == IW'(IDX_STS))  rd_mux = DW'({done, sts});
    for (int k = 0; k < RET_N; k++)
      if (idx == IW'(IDX_RET + k)) rd_mux = ret_flat[k*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
    else if (read_i) rdata_q <= '0;
  end

  assign readdata_o = rdata_q;

  // R9
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && (!aligned || int'(idx) > IDX_LAST || idx == IW'(IDX_START))) |=> (readdata_o == '0));
endmodule

// File: tb/acc_csr_slave_tb_top.sv
`timescale 1ns/1ps
module acc_csr_slave_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [7:0]   address;
  logic         write, read, core_done;
  logic [63:0]  writedata;
  logic [7:0]   byteenable;
  logic [63:0]  readdata;
  logic         start, busy, irq;
  logic [191:0] ret_drv;
  logic [31:0]  arg_a;
  logic [191:0] arg_b;
  logic [63:0]  arg_c;
  logic [7:0]   arg_d;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  acc_csr_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .address_i(address), .write_i(write),
    .writedata_i(writedata), .byteenable_i(byteenable), .read_i(read),
    .readdata_o(readdata), .start_o(start), .busy_o(busy), .core_done_i(core_done),
    .ret_data_i(ret_drv), .arg_a_o(arg_a), .arg_b_o(arg_b), .arg_c_o(arg_c),
    .arg_d_o(arg_d), .irq_o(irq)
  );

  // scoreboard
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          rd_pend = 0;

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_pend <= read;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {128'b0, readdata}, {128'b0, e});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic [7:0] be);
    address = a; writedata = d; byteenable = be; write = 1'b1;
    @(negedge clk);
    write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] e, input string tag);
    address = a; read = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    read = 1'b0;
  endtask

  // core stub: one-cycle completion pulse
  task automatic core_finish();
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
  endtask

  localparam logic [191:0] RET_A = 192'h0a0a0a0a_11111111_0b0b0b0b_22222222_0c0c0c0c_33333333;
  localparam logic [191:0] RET_B = 192'hf00df00d_44444444_cafecafe_55555555_beefbeef_66666666;

  initial begin
    rst_n = 1'b0; address = '0; write = 0; read = 0; core_done = 0;
    writedata = '0; byteenable = '0; ret_drv = RET_A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 busy_o", {191'b0, busy}, 0);
    chk("R1 start_o", {191'b0, start}, 0);
    chk("R1 irq_o", {191'b0, irq}, 0);
    chk("R1 arg_b_o", arg_b, 0);
    rd(8'h00, 0, "R1 busy word");
    rd(8'h18, 0, "R1 status word");
    rd(8'h10, 0, "R1 enable word");
    rd(8'h20, 0, "R1 result word");

    // R2 arguments
    wr(8'h38, 64'hffffffff_deadbeef, 8'hff);
    rd(8'h38, 64'h00000000_deadbeef, "R2 arg a reserved masked");
    chk("R2 arg_a_o", {160'b0, arg_a}, {160'b0, 32'hdeadbeef});
    wr(8'h40, 64'h01234567_89abcdef, 8'hff);
    wr(8'h48, 64'h10203040_50607080, 8'hff);
    wr(8'h50, 64'h99887766_55443322, 8'hff);
    rd(8'h40, 64'h01234567_89abcdef, "R2 arg b word0");
    rd(8'h48, 64'h10203040_50607080, "R2 arg b word1");
    rd(8'h50, 64'h99887766_55443322, "R2 arg b word2");
    chk("R2 arg_b_o", arg_b, 192'h99887766_55443322_10203040_50607080_01234567_89abcdef);
    wr(8'h58, 64'h11223344_55667788, 8'hff);
    wr(8'h58, 64'haaaaaaaa_aaaaaaaa, 8'h0f);
    rd(8'h58, 64'h11223344_aaaaaaaa, "R2 arg c byte enables");
    chk("R2 arg_c_o", {128'b0, arg_c}, {128'b0, 64'h11223344_aaaaaaaa});
    wr(8'h60, 64'hffffffff_ffffffff, 8'hff);
    rd(8'h60, 64'h00000000_000000ff, "R2 arg d reserved masked");
    wr(8'h60, 64'h0, 8'hfe);
    rd(8'h60, 64'h00000000_000000ff, "R2 arg d byte disabled");
    chk("R2 arg_d_o", {184'b0, arg_d}, {184'b0, 8'hff});

    // R9 unmapped, misaligned, read-only
    wr(8'h68, 64'hffffffff_ffffffff, 8'hff);
    rd(8'h68, 0, "R9 unmapped word");
    rd(8'hf8, 0, "R9 top word");
    wr(8'h20, 64'hffffffff_ffffffff, 8'hff);
    rd(8'h20, 0, "R9 result read-only");
    wr(8'h3c, 64'h0, 8'hff);
    rd(8'h38, 64'h00000000_deadbeef, "R9 misaligned write ignored");
    rd(8'h3c, 0, "R9 misaligned read");
    wr(8'h00, 64'h1, 8'hff);
    rd(8'h00, 0, "R9 busy read-only");

    // R8 enable
    wr(8'h10, 64'hffffffff_ffffffff, 8'hff);
    rd(8'h10, 64'h1, "R8 enable reserved masked");

    // R3 start
    wr(8'h08, 64'h1, 8'hff);
    chk("R3 start_o pulse", {191'b0, start}, 1);
    chk("R3 busy set", {191'b0, busy}, 1);
    @(negedge clk);
    chk("R3 start_o one cycle", {191'b0, start}, 0);
    rd(8'h00, 64'h1, "R5 busy word");
    rd(8'h08, 0, "R3 start reads zero");

    // R4 start while busy
    wr(8'h08, 64'h1, 8'hff);
    chk("R4 no start when busy", {191'b0, start}, 0);
    chk("R4 busy kept", {191'b0, busy}, 1);

    // R6 completion
    core_finish();
    ret_drv = RET_B;
    chk("R5 busy cleared", {191'b0, busy}, 0);
    chk("R8 irq raised", {191'b0, irq}, 1);
    rd(8'h18, 64'h3, "R6 done and status");
    rd(8'h20, RET_A[63:0], "R6 result word0");
    rd(8'h28, RET_A[127:64], "R6 result word1");
    rd(8'h30, RET_A[191:128], "R6 result word2");

    // R7 clear
    wr(8'h18, 64'h2, 8'hff);
    rd(8'h18, 64'h3, "R7 done not writable, bit0 zero no clear");
    wr(8'h18, 64'h1, 8'hfe);
    rd(8'h18, 64'h3, "R7 clear needs byte0 enable");
    wr(8'h18, 64'h1, 8'hff);
    chk("R8 irq cleared", {191'b0, irq}, 0);
    rd(8'h18, 64'h2, "R7 status cleared");

    // R6 done while idle ignored
    core_finish();
    rd(8'h18, 64'h2, "R6 idle done ignored");
    rd(8'h20, RET_A[63:0], "R6 result kept when idle");

    // R3 non-starting writes
    wr(8'h08, 64'h0, 8'hff);
    chk("R3 data zero no start", {191'b0, start}, 0);
    wr(8'h08, 64'h1, 8'hfe);
    chk("R3 byte0 off no start", {191'b0, start}, 0);
    chk("R3 busy still clear", {191'b0, busy}, 0);

    // R8 disabled interrupt
    wr(8'h10, 64'h0, 8'hff);
    wr(8'h08, 64'h1, 8'hff);
    chk("R3 second start", {191'b0, start}, 1);
    rd(8'h18, 64'h0, "R6 start clears done");
    core_finish();
    chk("R8 irq masked", {191'b0, irq}, 0);
    rd(8'h18, 64'h3, "R7 status set while masked");
    rd(8'h20, RET_B[63:0], "R6 second result");
    wr(8'h10, 64'h1, 8'h01);
    chk("R8 irq on enable", {191'b0, irq}, 1);

    // R7 completion and clear in one cycle
    wr(8'h18, 64'h1, 8'hff);
    wr(8'h08, 64'h1, 8'hff);
    @(negedge clk);
    address = 8'h18; writedata = 64'h1; byteenable = 8'hff; write = 1'b1; core_done = 1'b1;
    @(negedge clk);
    write = 1'b0; core_done = 1'b0;
    chk("R7 completion wins irq", {191'b0, irq}, 1);
    rd(8'h18, 64'h3, "R7 completion wins status");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 missing read data act=%0d exp=0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule